// File: doc/BRIEF.md
# Banked CPU Peripheral Address Decoder

This block sits on the address, data and strobe lines of an 8-bit processor with a 16-bit address space. From each valid bus cycle it derives the chip selects for two general RAM windows, a palette RAM window, a fixed ROM window, three small peripheral ports and an on-block 4-bit-wide nonvolatile store. It also holds the write-only control latches that steer the rest of the system:
- a program page number;
- an indicator latch;
- the video image page, horizontal translate, layer disables and palette bank.

A watchdog counter is part of the block. It is kicked through its own address.

Several of the latches behave as a plain bus latch does. A read cycle to a page, indicator or watchdog address loads whatever is on the undriven bus, which floats to 0xff. The indicator latch stores the complement of the data with its bit order reversed. The lowest quarter of the nonvolatile store can be locked by an active-low protect switch.

Top module: `bankio_decoder`

## Requirements
- R1: While bus_valid is high, sel_ram_lo is set for 0xa000-0xbfff, sel_pal for 0xc000-0xc7ff, sel_ram_hi for 0xd000-0xd7ff, sel_rom for 0xe000-0xffff and sel_nvm for 0xcc00-0xcfff. These selects are combinational, at most one is set, and all are low while bus_valid is low.
- R2: sel_port[0] is set for 0xc980-0xc9ff when address bits 3:2 are 00, and sel_port[1] when those bits are 01. sel_port[2] is set for 0xcb80-0xcb8f.
- R3: Any valid access to 0xc800-0xc87f loads page_q from bus bits 3:0 on the next clock. A read loads 0xf, because the bus floats to 0xff.
- R4: Any valid access to 0xc880-0xc8ff loads led_q with the complement of the bus byte, bit-reversed: led_q[i] = ~d[7-i]. A read therefore loads 0x00.
- R5: A valid access to 0xc900-0xc97f pulses wd_kick for one cycle only when (d AND 0x3e) equals 0x2a, with d = 0xff on a read. A kick clears the watchdog counter and wd_reset_req.
- R6: wd_reset_req rises after WD_TICKS (4096) clocks with tick_en high and no kick. It then stays high until a kick or reset.
- R7: A write to 0xcc00-0xcfff stores bus bits 3:0 at offset addr[9:0]. nvm_rdata shows {4'hf, stored nibble} for the address of the previous clock.
- R8: A nonvolatile write is dropped when offset bits 9:8 are 00 and prot_n is low. Writes to the other three quarters, and all writes while prot_n is high, are stored.
- R9: A write to 0xcbc0-0xcbcf loads img_page from bits 4:0 when addr[0]=0, and h_xlate from bits 5:0 when addr[0]=1.
- R10: A write to 0xcbd0-0xcbdf loads bg_dis from bit 0 and exp_dis from bit 1. A write to 0xcbe0-0xcbef loads pal_sel from bits 5:0. Reads of these video addresses leave all video registers unchanged.
- R11: Synchronous reset clears every latch, wd_kick, wd_reset_req and the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_valid | input | 1 | Bus cycle valid |
| prot_n | input | 1 | Protect switch, active low |
| tick_en | input | 1 | Watchdog tick enable |
| sel_ram_lo | output | 1 | Low general RAM select |
| sel_pal | output | 1 | Palette RAM select |
| sel_ram_hi | output | 1 | High general RAM select |
| sel_rom | output | 1 | Fixed ROM select |
| sel_nvm | output | 1 | Nonvolatile store select |
| sel_port | output | 3 | Peripheral port selects |
| nvm_rdata | output | 8 | Nonvolatile read data |
| page_q | output | 4 | Page latch |
| led_q | output | 8 | Indicator latch |
| img_page | output | 5 | Video image page |
| h_xlate | output | 6 | Horizontal translate |
| bg_dis | output | 1 | Background disable |
| exp_dis | output | 1 | Expander disable |
| pal_sel | output | 6 | Palette bank select |
| wd_kick | output | 1 | Watchdog kick pulse |
| wd_reset_req | output | 1 | Watchdog reset request |

## Verification
Random addresses are concentrated on each decoded window, with random low bits in the mirror span, and mixed with full-range addresses. This shows whether mirror bits are really don't-care and whether window edges are exact. Reads and writes are interleaved on the same latch addresses, so the floating-bus load can be told apart from a true ignore. Directed watchdog bytes that differ only in the masked-out bits separate a correct mask from a plain compare. Protected writes that land just below and just above the quarter boundary expose a wrong offset decode.

// File: rtl/bankio_pkg.sv
package bankio_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] FLOAT_BUS = 8'hff;
  localparam logic [DATA_W-1:0] KICK_MASK = 8'h3e;
  localparam logic [DATA_W-1:0] KICK_CODE = 8'h2a;

  typedef struct packed {
    logic ram_lo;
    logic pal;
    logic ram_hi;
    logic rom;
    logic nvm;
    logic port0;
    logic port1;
    logic port2;
    logic page;
    logic led;
    logic wdog;
    logic img;
    logic xlate;
    logic dis;
    logic psel;
  } hit_t;
endpackage

// File: rtl/bankio_addr_dec.sv
module bankio_addr_dec
  import bankio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output hit_t              hit
);
  always_comb begin
    hit = '0;
    if (valid) begin
      hit.ram_lo = addr[15:13] == 3'b101;
      hit.pal    = addr[15:11] == 5'b11000;
      hit.ram_hi = addr[15:11] == 5'b11010;
      hit.rom    = addr[15:13] == 3'b111;
      hit.nvm    = addr[15:10] == 6'b110011;
      hit.page   = addr[15:7] == 9'h190;
      hit.led    = addr[15:7] == 9'h191;
      hit.wdog   = addr[15:7] == 9'h192;
      hit.port0  = (addr[15:7] == 9'h193) && (addr[3:2] == 2'b00);
      hit.port1  = (addr[15:7] == 9'h193) && (addr[3:2] == 2'b01);
      hit.port2  = addr[15:4] == 12'hcb8;
      hit.img    = (addr[15:4] == 12'hcbc) && !addr[0];
      hit.xlate  = (addr[15:4] == 12'hcbc) && addr[0];
      hit.dis    = addr[15:4] == 12'hcbd;
      hit.psel   = addr[15:4] == 12'hcbe;
    end
  end
endmodule

// File: rtl/bankio_ctl_regs.sv
module bankio_ctl_regs
  import bankio_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int IMG_W   = 5,
  parameter int XLATE_W = 6,
  parameter int PSEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit_page,
  input  logic              hit_led,
  input  logic              hit_wdog,
  input  logic              hit_img,
  input  logic              hit_xlate,
  input  logic              hit_dis,
  input  logic              hit_psel,
  output logic [PAGE_W-1:0]  page_q,
  output logic [DATA_W-1:0]  led_q,
  output logic [IMG_W-1:0]   img_q,
  output logic [XLATE_W-1:0] xlate_q,
  output logic               bg_dis_q,
  output logic               exp_dis_q,
  output logic [PSEL_W-1:0]  psel_q,
  output logic               kick_q
);
  logic [DATA_W-1:0] bus_d;
  logic [DATA_W-1:0] led_next;

  assign bus_d = we ? wdata : FLOAT_BUS;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign led_next[i] = ~bus_d[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      led_q     <= '0;
      img_q     <= '0;
      xlate_q   <= '0;
      bg_dis_q  <= 1'b0;
      exp_dis_q <= 1'b0;
      psel_q    <= '0;
      kick_q    <= 1'b0;
    end else begin
      kick_q <= hit_wdog && ((bus_d & KICK_MASK) == KICK_CODE);
      if (hit_page) page_q <= bus_d[PAGE_W-1:0];
      if (hit_led)  led_q  <= led_next;
      if (we) begin
        if (hit_img)   img_q   <= bus_d[IMG_W-1:0];
        if (hit_xlate) xlate_q <= bus_d[XLATE_W-1:0];
        if (hit_dis) begin
          bg_dis_q  <= bus_d[0];
          exp_dis_q <= bus_d[1];
        end
        if (hit_psel) psel_q <= bus_d[PSEL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bankio_wdog.sv
module bankio_wdog #(
  parameter int TICKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic tick_en,
  output logic req
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (tick_en && !req) begin
      if (cnt == LAST) begin
        cnt <= '0;
        req <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bankio_nvm.sv
module bankio_nvm #(
  parameter int AW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bankio_decoder.sv
module bankio_decoder
  import bankio_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int IMG_W    = 5,
  parameter int XLATE_W  = 6,
  parameter int PSEL_W   = 6,
  parameter int NVM_AW   = 10,
  parameter int NVM_DW   = 4,
  parameter int WD_TICKS = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  input  logic                bus_valid,
  input  logic                prot_n,
  input  logic                tick_en,
  output logic                sel_ram_lo,
  output logic                sel_pal,
  output logic                sel_ram_hi,
  output logic                sel_rom,
  output logic                sel_nvm,
  output logic [2:0]          sel_port,
  output logic [DATA_W-1:0]   nvm_rdata,
  output logic [PAGE_W-1:0]   page_q,
  output logic [DATA_W-1:0]   led_q,
  output logic [IMG_W-1:0]    img_page,
  output logic [XLATE_W-1:0]  h_xlate,
  output logic                bg_dis,
  output logic                exp_dis,
  output logic [PSEL_W-1:0]   pal_sel,
  output logic                wd_kick,
  output logic                wd_reset_req
);
  localparam int HI_W = DATA_W - NVM_DW;

  hit_t              hit;
  logic              nvm_lock;
  logic              nvm_wr;
  logic [NVM_DW-1:0] nvm_q;

  bankio_addr_dec u_dec (
    .addr  (bus_addr),
    .valid (bus_valid),
    .hit   (hit)
  );

  assign sel_ram_lo = hit.ram_lo;
  assign sel_pal    = hit.pal;
  assign sel_ram_hi = hit.ram_hi;
  assign sel_rom    = hit.rom;
  assign sel_nvm    = hit.nvm;
  assign sel_port   = {hit.port2, hit.port1, hit.port0};

  bankio_ctl_regs #(
    .PAGE_W  (PAGE_W),
    .IMG_W   (IMG_W),
    .XLATE_W (XLATE_W),
    .PSEL_W  (PSEL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .hit_page  (hit.page),
    .hit_led   (hit.led),
    .hit_wdog  (hit.wdog),
    .hit_img   (hit.img),
    .hit_xlate (hit.xlate),
    .hit_dis   (hit.dis),
    .hit_psel  (hit.psel),
    .page_q    (page_q),
    .led_q     (led_q),
    .img_q     (img_page),
    .xlate_q   (h_xlate),
    .bg_dis_q  (bg_dis),
    .exp_dis_q (exp_dis),
    .psel_q    (pal_sel),
    .kick_q    (wd_kick)
  );

  bankio_wdog #(.TICKS(WD_TICKS)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .kick    (wd_kick),
    .tick_en (tick_en),
    .req     (wd_reset_req)
  );

  assign nvm_lock = (bus_addr[NVM_AW-1 -: 2] == 2'b00) && !prot_n;
  assign nvm_wr   = hit.nvm && bus_we && !nvm_lock;

  bankio_nvm #(.AW(NVM_AW), .DW(NVM_DW)) u_nvm (
    .clk   (clk),
    .wr_en (nvm_wr),
    .addr  (bus_addr[NVM_AW-1:0]),
    .wdata (bus_wdata[NVM_DW-1:0]),
    .rdata (nvm_q)
  );

  assign nvm_rdata = {FLOAT_BUS[DATA_W-1 -: HI_W], nvm_q};
endmodule

// File: rtl/bankio_decoder_chk.sv
module bankio_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_we,
  input logic        bus_valid,
  input logic        prot_n,
  input logic        tick_en,
  input logic        sel_ram_lo,
  input logic        sel_pal,
  input logic        sel_ram_hi,
  input logic        sel_rom,
  input logic        sel_nvm,
  input logic [2:0]  sel_port,
  input logic [7:0]  nvm_rdata,
  input logic [3:0]  page_q,
  input logic [7:0]  led_q,
  input logic [4:0]  img_page,
  input logic [5:0]  h_xlate,
  input logic        bg_dis,
  input logic        exp_dis,
  input logic [5:0]  pal_sel,
  input logic        wd_kick,
  input logic        wd_reset_req
);
  logic [7:0] sels;
  assign sels = {sel_ram_lo, sel_pal, sel_ram_hi, sel_rom, sel_nvm, sel_port};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sels)); // R1
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (sels == 8'h00)); // R1
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_addr[15:7] == 9'h190) |=> $stable(page_q)); // R3
  AST_LED_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_addr[15:7] == 9'h191) |=> (led_q == 8'h00)); // R4
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wd_kick |=> !wd_reset_req); // R5
  AST_REQ_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_reset_req) |-> $past(tick_en)); // R6
  AST_PSEL_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_addr[15:4] == 12'hcbe) |=> $stable(pal_sel)); // R10
endmodule

bind bankio_decoder bankio_decoder_chk u_chk (.*);

// File: tb/bankio_decoder_tb.sv
module bankio_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_valid, prot_n, tick_en;
  logic        sel_ram_lo, sel_pal, sel_ram_hi, sel_rom, sel_nvm;
  logic [2:0]  sel_port;
  logic [7:0]  nvm_rdata, led_q;
  logic [3:0]  page_q;
  logic [4:0]  img_page;
  logic [5:0]  h_xlate, pal_sel;
  logic        bg_dis, exp_dis, wd_kick, wd_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_page;
  logic [7:0] m_led;
  logic [4:0] m_img;
  logic [5:0] m_xl, m_psel;
  logic       m_bg, m_ex, m_kick;
  logic [3:0] m_mem [1024];

  always #2 clk = ~clk;

  bankio_decoder u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input logic [15:0] a);
    logic [7:0] s = 8'h00;
    s[7] = a >= 16'ha000 && a <= 16'hbfff;
    s[6] = a >= 16'hc000 && a <= 16'hc7ff;
    s[5] = a >= 16'hd000 && a <= 16'hd7ff;
    s[4] = a >= 16'he000;
    s[3] = a >= 16'hcc00 && a <= 16'hcfff;
    s[2] = a >= 16'hcb80 && a <= 16'hcb8f;
    s[1] = a >= 16'hc980 && a <= 16'hc9ff && (a & 16'h000c) == 16'h0004;
    s[0] = a >= 16'hc980 && a <= 16'hc9ff && (a & 16'h000c) == 16'h0000;
    return s;
  endfunction

  function automatic logic [7:0] rev_inv(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ~d[7-i];
    return r;
  endfunction

  task automatic model_reset();
    m_page = 0; m_led = 0; m_img = 0; m_xl = 0; m_psel = 0;
    m_bg = 0; m_ex = 0; m_kick = 0;
  endtask

  task automatic chk_latches();
    chk("R3 page", page_q, m_page);
    chk("R4 led", led_q, m_led);
    chk("R5 kick", wd_kick, m_kick);
    chk("R9 img", img_page, m_img);
    chk("R9 xlate", h_xlate, m_xl);
    chk("R10 dis", {bg_dis, exp_dis}, {m_bg, m_ex});
    chk("R10 psel", pal_sel, m_psel);
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d, input logic pn);
    logic [7:0] bd;
    bit rd_nvm;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; bus_valid = 1'b1; prot_n = pn;
    #1;
    if (a[15:7] >= 9'h193 && a[15:7] <= 9'h193 || a[15:8] == 8'hcb)
      chk("R2 sel", {sel_ram_lo, sel_pal, sel_ram_hi, sel_rom, sel_nvm, sel_port}, exp_sel(a));
    else
      chk("R1 sel", {sel_ram_lo, sel_pal, sel_ram_hi, sel_rom, sel_nvm, sel_port}, exp_sel(a));
    bd = we ? d : 8'hff;
    m_kick = 1'b0;
    rd_nvm = 0;
    if (a >= 16'hc800 && a <= 16'hc87f) m_page = bd[3:0];
    if (a >= 16'hc880 && a <= 16'hc8ff) m_led = rev_inv(bd);
    if (a >= 16'hc900 && a <= 16'hc97f) m_kick = (bd & 8'h3e) == 8'h2a;
    if (we && a[15:4] == 12'hcbc) begin
      if (a[0]) m_xl = bd[5:0]; else m_img = bd[4:0];
    end
    if (we && a[15:4] == 12'hcbd) begin m_bg = bd[0]; m_ex = bd[1]; end
    if (we && a[15:4] == 12'hcbe) m_psel = bd[5:0];
    if (a[15:10] == 6'b110011) begin
      if (!we) rd_nvm = 1;
      else if (!(a[9:8] == 2'b00 && !pn)) m_mem[a[9:0]] = d[3:0];
    end
    @(negedge clk);
    chk_latches();
    if (rd_nvm) chk("R7 R8 nvm read", nvm_rdata, {4'hf, m_mem[a[9:0]]});
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'h1bad5eed));
    rst = 1; bus_addr = 0; bus_wdata = 0; bus_we = 0; bus_valid = 0;
    prot_n = 1; tick_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_latches();                                 // R11 reset state
    chk("R11 req", wd_reset_req, 1'b0);

    for (int i = 0; i < 1024; i++) access(16'hcc00 + 16'(i), 1'b1, 8'(i), 1'b1);

    // directed latch corners
    access(16'hc87f, 1'b1, 8'ha5, 1'b1);           // R3 mirror top
    access(16'hc800, 1'b0, 8'h00, 1'b1);           // R3 read loads 0xf
    access(16'hc8c3, 1'b1, 8'h01, 1'b1);           // R4 -> 0x7f
    chk("R4 value", led_q, 8'h7f);
    access(16'hc880, 1'b0, 8'h00, 1'b1);           // R4 read -> 0
    access(16'hc900, 1'b1, 8'heb, 1'b1);           // R5 masked match
    access(16'hc97f, 1'b1, 8'h2e, 1'b1);           // R5 no match
    access(16'hc940, 1'b0, 8'h00, 1'b1);           // R5 read no kick
    access(16'hcbe0, 1'b1, 8'h3c, 1'b1);           // R10
    access(16'hcbe7, 1'b0, 8'h00, 1'b1);           // R10 read ignored
    access(16'hcbd5, 1'b1, 8'h02, 1'b1);           // R10 disables
    access(16'hcbcf, 1'b1, 8'h2b, 1'b1);           // R9 xlate
    access(16'hcbce, 1'b1, 8'hff, 1'b1);           // R9 img
    access(16'hccff, 1'b1, 8'h09, 1'b0);           // R8 blocked
    access(16'hccff, 1'b0, 8'h00, 1'b0);
    access(16'hcd00, 1'b1, 8'h06, 1'b0);           // R8 next quarter stored
    access(16'hcd00, 1'b0, 8'h00, 1'b0);
    access(16'hcc00, 1'b1, 8'h0c, 1'b1);           // R8 unlocked
    access(16'hcc00, 1'b0, 8'h00, 1'b1);
    access(16'hc983, 1'b0, 8'h00, 1'b1);           // R2 port 0
    access(16'hc9f7, 1'b0, 8'h00, 1'b1);           // R2 port 1
    access(16'hc9f8, 1'b0, 8'h00, 1'b1);           // R2 gap
    access(16'hcb8c, 1'b0, 8'h00, 1'b1);           // R2 port 2
    access(16'hbfff, 1'b0, 8'h00, 1'b1);           // R1 edges
    access(16'hc7ff, 1'b0, 8'h00, 1'b1);
    access(16'hd7ff, 1'b0, 8'h00, 1'b1);
    access(16'hd800, 1'b0, 8'h00, 1'b1);
    access(16'he000, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    #1 chk("R1 idle", {sel_ram_lo, sel_pal, sel_ram_hi, sel_rom, sel_nvm, sel_port}, 8'h00);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] r = 16'($urandom);
      case ($urandom % 8)
        0: a = r;
        1: a = 16'hc800 | (r & 16'h007f);
        2: a = 16'hc880 | (r & 16'h007f);
        3: a = 16'hc900 | (r & 16'h007f);
        4: a = 16'hc980 | (r & 16'h007f);
        5: a = 16'hcb80 | (r & 16'h007f);
        6: a = 16'hcc00 | (r & 16'h03ff);
        default: a = 16'ha000 + (r % 16'h6000);
      endcase
      access(a, 1'($urandom), 8'($urandom), 1'($urandom));
    end

    // watchdog timing
    access(16'hc900, 1'b1, 8'h2a, 1'b1);
    @(negedge clk);
    tick_en = 1;
    repeat (4095) @(negedge clk);
    chk("R6 before limit", wd_reset_req, 1'b0);
    @(negedge clk);
    chk("R6 at limit", wd_reset_req, 1'b1);
    repeat (10) @(negedge clk);
    chk("R6 sticky", wd_reset_req, 1'b1);
    access(16'hc900, 1'b1, 8'h2e, 1'b1);
    @(negedge clk);
    chk("R5 no clear", wd_reset_req, 1'b1);
    access(16'hc911, 1'b1, 8'h2b, 1'b1);
    @(negedge clk);
    chk("R5 clear", wd_reset_req, 1'b0);
    tick_en = 0;

    // reset clears latches
    access(16'hc800, 1'b1, 8'h07, 1'b1);
    access(16'hcbe0, 1'b1, 8'h15, 1'b1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    model_reset();
    chk_latches();                                 // R11
    chk("R11 req after", wd_reset_req, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule